// File: doc/BRIEF.md
# Quasi-Bidirectional I2C Port Expander

This block is an I2C target that presents eight general-purpose pins as a single byte, with no register index in either direction. A controller write loads an output latch; a controller read returns the levels actually present on the pins. No direction register exists. A latch bit of 1 turns on only the weak pull-up for that pin, so the pin floats high and can be pulled low from outside to act as an input. A latch bit of 0 turns on the strong pull-down. For each pin the block drives a strong-low enable and a weak-pull-up enable. The pad and resistor models sit outside the block.

SCL and SDA are oversampled on the system clock. Start and stop conditions are found from SDA edges while SCL is high. The block controls SDA as open drain through a single pull-low enable. Pin inputs pass through a synchroniser. An active-low interrupt goes low when the synchronised pin byte differs from the byte captured at the most recent read. The next read clears it. The 7-bit target address is a fixed 4-bit prefix, chosen by a parameter, with three strap inputs as its low bits.

Top module: `qio_expander`

## Requirements
- R1: The target answers address {P, strap[2:0]}, where P is 4'b0100 when ALT_VARIANT=0 (0x20 to 0x27) and 4'b0111 when ALT_VARIANT=1 (0x38 to 0x3F). On a match it acknowledges by pulling SDA low during the ninth clock of the address byte.
- R2: On a non-matching address the target gives no acknowledge and ignores everything up to the next start condition. SDA is never pulled low and the latch does not change.
- R3: After reset the latch is 8'hFF. drive_low is 8'h00, pullup_en is 8'hFF, irq_n is 1 and sda_oe is 0.
- R4: In a write transaction every data byte is acknowledged. Each byte replaces all eight latch bits on the rising SCL edge of its acknowledge clock, so after several bytes the last one remains.
- R5: For each pin n, latch bit 1 gives pullup_en[n]=1 and drive_low[n]=0. Latch bit 0 gives drive_low[n]=1 and pullup_en[n]=0.
- R6: A read transaction sends the synchronised pin byte MSB first (bit n = pin n), not the latch. The byte is captured again for every byte the controller acknowledges. After a not-acknowledge the target releases SDA.
- R7: irq_n is low exactly while the synchronised pin byte differs from the reference byte. The reference is the byte captured by the most recent read, or 8'hFF after reset.
- R8: A read capture takes the captured byte as the new reference and drives irq_n high on the next cycle.
- R9: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap | input | 3 | Low three address bits |
| pin_i | input | 8 | Sensed level of each I/O pin |
| drive_low | output | 8 | Strong pull-down enable per pin |
| pullup_en | output | 8 | Weak pull-up enable per pin |
| irq_n | output | 1 | Active-low input-change interrupt |

## Verification
A read capture can land in the same clock as a change of a synchronised pin level. In that clock the interrupt's clear path and its set path act on the same cycle. The bench provokes this by flipping an externally pulled pin at delays of zero to seven system clocks after the falling SCL edge that ends the address byte. This sweeps the change across the capture point. The returned byte must equal either the old or the new pin byte. After the stop, irq_n must be high exactly when the current pins equal the byte that was returned.

// File: rtl/i2cq_pkg.sv
`timescale 1ns/1ps
package i2cq_pkg;
  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 3;
  localparam int PFX_W   = 7 - STRAP_W;
  localparam logic [PFX_W-1:0] PFX_BASE = 4'b0100;
  localparam logic [PFX_W-1:0] PFX_ALT  = 4'b0111;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_END, ST_A_ACK,
    ST_RX, ST_RX_END, ST_W_ACK, ST_TX, ST_TX_ACK
  } tgt_state_t;
endpackage

// File: rtl/i2cq_sync.sv
`timescale 1ns/1ps
module i2cq_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cq_target.sv
`timescale 1ns/1ps
module i2cq_target
  import i2cq_pkg::*;
#(
  parameter logic [PFX_W-1:0] ADDR_PREFIX = PFX_BASE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd_byte,
  output logic               sda_oe,
  output logic               wr_stb,
  output logic [BYTE_W-1:0]  wr_byte,
  output logic               rd_cap
);
  localparam int CNT_W = $clog2(BYTE_W);

  tgt_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txbyte;
  logic              rw_q, ack_ok, scl_q, sda_q;
  logic              scl_rise, scl_fall, start_c, stop_c, addr_hit;

  always_comb begin
    scl_rise = scl_s & ~scl_q;
    scl_fall = ~scl_s & scl_q;
    start_c  = scl_q & scl_s & sda_q & ~sda_s;
    stop_c   = scl_q & scl_s & ~sda_q & sda_s;
    addr_hit = (shreg[BYTE_W-1:1] == {ADDR_PREFIX, strap});
    wr_stb   = scl_rise && (state == ST_W_ACK);
    wr_byte  = shreg;
    rd_cap   = scl_fall && (((state == ST_ADDR_END) && addr_hit && shreg[0]) ||
                            ((state == ST_TX_ACK) && ack_ok));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      txbyte <= '1;
      sda_oe <= 1'b0;
      rw_q   <= 1'b0;
      ack_ok <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (start_c) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_RX: if (scl_rise) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
            if (cnt == CNT_W'(BYTE_W-1))
              state <= (state == ST_ADDR) ? ST_ADDR_END : ST_RX_END;
          end
          ST_ADDR_END: if (scl_fall) begin
            if (addr_hit) begin
              sda_oe <= 1'b1;
              rw_q   <= shreg[0];
              state  <= ST_A_ACK;
              if (shreg[0]) txbyte <= rd_byte;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_A_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw_q) begin
              sda_oe <= ~txbyte[BYTE_W-1];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_RX_END: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_W_ACK;
          end
          ST_W_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_RX;
          end
          ST_TX: if (scl_fall) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(BYTE_W-1)) begin
              sda_oe <= 1'b0;
              state  <= ST_TX_ACK;
            end else begin
              txbyte <= {txbyte[BYTE_W-2:0], 1'b1};
              sda_oe <= ~txbyte[BYTE_W-2];
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) ack_ok <= ~sda_s;
            if (scl_fall) begin
              cnt <= '0;
              if (ack_ok) begin
                txbyte <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_s)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe); // R2
endmodule

// File: rtl/i2cq_change.sv
`timescale 1ns/1ps
module i2cq_change #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_s,
  input  logic         rd_cap,
  output logic         irq_n
);
  logic [W-1:0] ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '1;
      irq_n <= 1'b1;
    end else if (rd_cap) begin
      ref_q <= pin_s;
      irq_n <= 1'b1;
    end else begin
      irq_n <= (pin_s == ref_q);
    end
  end

  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    rd_cap |=> irq_n); // R8
  AST_IRQ_ON_DIFF: assert property (@(posedge clk) disable iff (rst)
    (!rd_cap && (pin_s != ref_q)) |=> !irq_n); // R7
endmodule

// File: rtl/qio_expander.sv
`timescale 1ns/1ps
module qio_expander
  import i2cq_pkg::*;
#(
  parameter bit ALT_VARIANT = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  pin_i,
  output logic [BYTE_W-1:0]  drive_low,
  output logic [BYTE_W-1:0]  pullup_en,
  output logic               irq_n
);
  localparam logic [PFX_W-1:0] PREFIX = ALT_VARIANT ? PFX_ALT : PFX_BASE;

  logic [1:0]        bus_s;
  logic [BYTE_W-1:0] pin_s;
  logic [BYTE_W-1:0] latch_q;
  logic [BYTE_W-1:0] wr_byte;
  logic              wr_stb, rd_cap;

  i2cq_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(bus_s));

  i2cq_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_pin_sync (
    .clk(clk), .rst(rst), .d(pin_i), .q(pin_s));

  i2cq_target #(.ADDR_PREFIX(PREFIX)) u_target (
    .clk(clk), .rst(rst), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .strap(strap), .rd_byte(pin_s), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_cap(rd_cap));

  i2cq_change #(.W(BYTE_W)) u_change (
    .clk(clk), .rst(rst), .pin_s(pin_s), .rd_cap(rd_cap), .irq_n(irq_n));

  always_ff @(posedge clk) begin
    if (rst)         latch_q <= '1;
    else if (wr_stb) latch_q <= wr_byte;
  end

  generate
    for (genvar g = 0; g < BYTE_W; g++) begin : g_pad
      logic dl_q, pu_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          dl_q <= 1'b0;
          pu_q <= 1'b1;
        end else begin
          dl_q <= ~latch_q[g];
          pu_q <= latch_q[g];
        end
      end
      assign drive_low[g] = dl_q;
      assign pullup_en[g] = pu_q;
    end
  endgenerate

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(latch_q)); // R4
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> (latch_q == $past(wr_byte))); // R4
  AST_PAD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (drive_low == ~$past(latch_q))); // R5
endmodule

// File: tb/qio_expander_tb.sv
`timescale 1ns/1ps
module qio_expander_tb;
  localparam int H = 12;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] OWN = {4'b0100, STRAP};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, scl_m, sda_m, sda_oe, irq_n;
  logic [7:0] ext_low, drive_low, pullup_en;
  wire sda_line = sda_m & ~sda_oe;
  wire [7:0] pin_i = ~(drive_low | ext_low);

  qio_expander u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(STRAP), .pin_i(pin_i), .drive_low(drive_low),
    .pullup_en(pullup_en), .irq_n(irq_n));

  int checks = 0, errors = 0, r9_bad = 0;
  logic [7:0] latch_m = 8'hFF, ref_m = 8'hFF;
  logic oe_prev = 1'b0;
  int g_delay;
  logic [7:0] g_mask;
  int unsigned seed_v;

  function automatic logic [7:0] pins_exp();
    return latch_m & ~ext_low;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (sda_oe !== oe_prev && scl_m) r9_bad++;
      oe_prev = sda_oe;
    end
  end

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    repeat (3) @(negedge clk);
    sda_m = 1'b1; half(); scl_m = 1'b1; half();
    sda_m = 1'b0; half(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    repeat (3) @(negedge clk);
    sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
  endtask

  task automatic put_bit(input logic b);
    repeat (3) @(negedge clk);
    sda_m = b; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    repeat (3) @(negedge clk);
    sda_m = 1'b1; half(); scl_m = 1'b1;
    repeat (H/2) @(negedge clk);
    b = sda_line;
    repeat (H - H/2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nk);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(nk);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic last);
    logic bb;
    for (int i = 7; i >= 0; i--) begin get_bit(bb); b[i] = bb; end
    put_bit(last);
  endtask

  task automatic settle_checks();
    repeat (8) @(negedge clk);
    chk(drive_low == ~latch_m && pullup_en == latch_m, "R5 pad enables",
        {drive_low, pullup_en}, {~latch_m, latch_m});
    chk(irq_n == (pins_exp() == ref_m), "R7 irq vs reference", irq_n, pins_exp() == ref_m);
  endtask

  task automatic wr_txn(input logic [6:0] a, input int n, input logic [7:0] d0,
                        input logic [7:0] d1, input logic [7:0] d2);
    logic nk;
    logic [7:0] d;
    bit hit;
    hit = (a == OWN);
    bus_start();
    send_byte({a, 1'b0}, nk);
    if (hit) chk(nk == 1'b0, "R1 own address ack", nk, 0);
    else     chk(nk == 1'b1, "R2 foreign address nack", nk, 1);
    for (int k = 0; k < n; k++) begin
      d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
      send_byte(d, nk);
      if (hit) begin
        chk(nk == 1'b0, "R4 data byte ack", nk, 0);
        latch_m = d;
      end else begin
        chk(nk == 1'b1, "R2 ignored data nack", nk, 1);
      end
    end
    bus_stop();
    settle_checks();
  endtask

  task automatic rd_txn(input int n, input bit glitch);
    logic nk;
    logic [7:0] got, oldp, newp;
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(i == 0 ? 1'b1 : OWN[i-1]);
    oldp = pins_exp();
    newp = latch_m & ~(ext_low ^ g_mask);
    if (glitch) begin
      fork
        begin
          repeat (g_delay) @(negedge clk);
          ext_low = ext_low ^ g_mask;
        end
      join_none
    end
    get_bit(nk);
    chk(nk == 1'b0, "R1 read address ack", nk, 0);
    for (int k = 0; k < n; k++) begin
      recv_byte(got, k == n - 1);
      if (glitch && k == 0)
        chk(got == oldp || got == newp, "R6 R8 capture collision byte", got, newp);
      else
        chk(got == pins_exp(), "R6 read returns pin levels", got, pins_exp());
      ref_m = got;
    end
    repeat (8) @(negedge clk);
    chk(sda_oe == 1'b0, "R6 release after nack", sda_oe, 0);
    bus_stop();
    repeat (8) @(negedge clk);
    chk(irq_n == (pins_exp() == ref_m), "R8 irq after read", irq_n, pins_exp() == ref_m);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'd20240611);
    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; ext_low = 8'h00; g_mask = 8'h00; g_delay = 0;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(drive_low == 8'h00, "R3 reset drive_low", drive_low, 0);
    chk(pullup_en == 8'hFF, "R3 reset pullup_en", pullup_en, 8'hFF);
    chk(irq_n == 1'b1, "R3 reset irq_n", irq_n, 1);
    chk(sda_oe == 1'b0, "R3 reset sda_oe", sda_oe, 0);

    wr_txn({4'b0111, STRAP}, 1, 8'h00, 8'h00, 8'h00);
    wr_txn({4'b0100, 3'b100}, 1, 8'h0F, 8'h00, 8'h00);
    wr_txn(OWN, 1, 8'h5A, 8'h00, 8'h00);
    rd_txn(1, 1'b0);
    ext_low = 8'h02;
    repeat (10) @(negedge clk);
    chk(irq_n == 1'b0, "R7 irq on pin change", irq_n, 0);
    rd_txn(1, 1'b0);
    chk(ref_m == 8'h58, "R6 read differs from latch", ref_m, 8'h58);
    ext_low = 8'h00;
    repeat (10) @(negedge clk);
    chk(irq_n == 1'b0, "R7 irq on release", irq_n, 0);
    wr_txn(OWN, 3, 8'h11, 8'h22, 8'hC3);
    chk(latch_m == 8'hC3 && pullup_en == 8'hC3, "R4 last byte wins", pullup_en, 8'hC3);
    rd_txn(3, 1'b0);

    wr_txn(OWN, 1, 8'hFF, 8'h00, 8'h00);
    for (int d = 0; d < 8; d++) begin
      g_delay = d;
      g_mask = 8'h01 << d;
      rd_txn(1, 1'b1);
      g_mask = 8'h00;
    end

    for (int t = 0; t < 30; t++) begin
      int op;
      logic [6:0] a;
      op = int'($urandom % 4);
      case (op)
        0: wr_txn(OWN, int'($urandom % 3) + 1, 8'($urandom), 8'($urandom), 8'($urandom));
        1: rd_txn(int'($urandom % 3) + 1, 1'b0);
        2: begin
          a = 7'($urandom);
          if (a == OWN) a = a ^ 7'h01;
          wr_txn(a, 1, 8'($urandom), 8'h00, 8'h00);
        end
        default: begin
          ext_low = 8'($urandom);
          repeat (10) @(negedge clk);
          chk(irq_n == (pins_exp() == ref_m), "R7 random pin change", irq_n, pins_exp() == ref_m);
        end
      endcase
    end

    chk(r9_bad == 0, "R9 sda_oe moved while SCL high", r9_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule